// File: doc/BRIEF.md
# Chained Peripheral Transfer Sequencer

This block moves data on behalf of peripheral events such as "receive buffer full" or "transmit buffer empty", so the CPU does not have to. Each request source owns one bit in an activation-enable register. When an enabled source raises a request, the sequencer first reads that source's vector word from a control RAM port. The vector names a control record. The sequencer then loads the record and performs one data move on a separate data port: a read from the source address followed by a write to the destination address. It then writes the updated record back. If the record's chain flag is set, the sequencer continues with the record that follows it.

Each record carries a transfer count, a reload size, two addresses with per-address increment controls, and mode flags. The count can run out. In normal mode, a count that goes from 1 to 0 always clears the source's enable bit. In repeat mode, it does so only when the record's repeat-interrupt flag is set. For receive-type sources, the same event also pulses a CPU interrupt. In repeat mode the count reloads itself, and the address on the repeat side goes back to where the block of transfers began.

The sequencer never touches a peripheral's ready flag itself. It marks each data access with a qualifier that allows the peripheral to clear its own flag as a side effect. Once an enable bit has been cleared during an activation, the qualifier stays low for the rest of that chain. Requests that arrive while the sequencer is busy are held and served afterwards. When a request is taken while the non-maskable flag is high, it is discarded without any transfer.

Top module: `xfer_chain_seq`

## Requirements
- R1: After reset, `busy`, `irq_pulse`, `ctl_req` and `dat_req` are 0 and all enable bits are 0.
- R2: Writing `en_wdata` with `en_wr` high loads the enable register. A request from a source whose enable bit is 0 is ignored: no memory access occurs and `busy` stays low.
- R3: If `nmi_flag` is high when a held request is taken, the request is discarded. No memory access is made and no state changes.
- R4: An activation makes its accesses in this order: a vector read at control address equal to the source index, whose low IDX_W bits give the record index; a record read at REC_BASE+index; a data read at the source address; a data write of that byte to the destination address; a record write-back. `busy` is high from the vector read through the last write-back, and only one port is requested at a time.
- R5: Record word layout at default widths: bit 0 repeat mode, bit 1 repeat side (0 source, 1 destination), bit 2 chain, bit 3 repeat-interrupt enable, bit 4 source increment, bit 5 destination increment, [13:6] count, [21:14] reload size, [37:22] source address, [53:38] destination address.
- R6: Write-back stores the count minus one and each address plus its increment bit. All flags and the reload size are unchanged.
- R7: In repeat mode, a count of 1 is written back as the reload size. If the repeat-side address has its increment bit set, it is written back as address + 1 - reload, which is its value at the start of the block.
- R8: If the chain bit is 1 after a write-back, the record at index+1 is processed next within the same activation. If the chain bit is 0, the activation ends.
- R9: A normal-mode transfer whose count is 1 clears the activating source's enable bit at its write-back. If the source is a receive type (RX_MASK bit set, sources 0 to 3 by default), it also gives a one-cycle `irq_pulse` with `irq_src` equal to the source.
- R10: A repeat-mode transfer whose count is 1 has the R9 effect only when repeat-interrupt enable is 1. Otherwise the enable bit and the interrupt output are unchanged.
- R11: `dat_clr_ok` is high on every data access up to and including the transfer that triggers an R9/R10 clear, and low on every data access after it in the same activation.
- R12: Requests are held while the sequencer is busy. Held requests are served one activation at a time, lowest source index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | NUM_SRC | Request pulse per source |
| nmi_flag | input | 1 | Non-maskable event pending; discards taken requests |
| en_wr | input | 1 | Load the enable register |
| en_wdata | input | NUM_SRC | New enable bits |
| en_q | output | NUM_SRC | Current enable bits |
| busy | output | 1 | Activation in progress |
| ctl_req | output | 1 | Control RAM access request |
| ctl_we | output | 1 | Control RAM write |
| ctl_addr | output | CTL_AW | Control RAM word address |
| ctl_wdata | output | REC_W | Record written back |
| ctl_rdata | input | REC_W | Vector or record read |
| ctl_ack | input | 1 | Control access complete |
| dat_req | output | 1 | Data access request |
| dat_we | output | 1 | Data write |
| dat_addr | output | ADDR_W | Data address |
| dat_wdata | output | DATA_W | Data written |
| dat_rdata | input | DATA_W | Data read |
| dat_ack | input | 1 | Data access complete |
| dat_clr_ok | output | 1 | Access may clear the peripheral ready flag |
| irq_pulse | output | 1 | CPU interrupt request pulse |
| irq_src | output | SRC_W | Source that raised the interrupt |

## Verification
The bench targets the count-of-1 edge in both modes. A wrong expiry rule would leave an enable bit set or clear one that should remain, give interrupts for transmit sources, or skip the reload. Directed repeat-mode records check the restart address. An off-by-one error there would leave the address one step away from where the block started. Chains that cross an expiry check the side-effect qualifier, which a faulty design would keep high for too long or drop too early. Simultaneous requests, and requests that arrive while an activation is running, are checked against the lowest-index-first order. A broken hold would lose a request or serve it in the wrong order.

// File: rtl/xcs_pkg.sv
package xcs_pkg;
   // Flag bit positions inside a control record word
   localparam int unsigned F_RPT    = 0;
   localparam int unsigned F_RSIDE  = 1;
   localparam int unsigned F_CHAIN  = 2;
   localparam int unsigned F_RPTINT = 3;
   localparam int unsigned F_SINC   = 4;
   localparam int unsigned F_DINC   = 5;
   localparam int unsigned FLAG_W   = 6;

   typedef enum logic [2:0] {
      S_IDLE, S_VEC, S_REC, S_DRD, S_DWR, S_WB
   } seq_st_e;
endpackage

// File: rtl/xcs_pend.sv
module xcs_pend #(
   parameter int NS = 8,
   parameter int SW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NS-1:0] req_in,
   input  logic [NS-1:0] en_q,
   input  logic          take,
   output logic          pend_any,
   output logic [SW-1:0] pick_idx
);
   logic [NS-1:0] pend_q;
   logic [NS-1:0] take_mask;

   always_comb begin
      pick_idx = '0;
      for (int i = NS - 1; i >= 0; i--) begin
         if (pend_q[i]) pick_idx = SW'(i);
      end
   end

   assign pend_any  = |pend_q;
   assign take_mask = take ? (NS'(1) << pick_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~take_mask) | (req_in & en_q);
   end
endmodule

// File: rtl/xcs_enreg.sv
module xcs_enreg #(
   parameter int NS = 8,
   parameter int SW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_wr,
   input  logic [NS-1:0] en_wdata,
   input  logic          clr,
   input  logic [SW-1:0] clr_idx,
   output logic [NS-1:0] en_q
);
   for (genvar g = 0; g < NS; g++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          bit_q <= 1'b0;
         else if (en_wr)                      bit_q <= en_wdata[g];
         else if (clr && clr_idx == SW'(g))   bit_q <= 1'b0;
      end
      assign en_q[g] = bit_q;
   end
endmodule

// File: rtl/xcs_update.sv
module xcs_update
   import xcs_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 8,
   parameter int RW = FLAG_W + 2 * CW + 2 * AW
) (
   input  logic [RW-1:0] rec_i,
   output logic [RW-1:0] rec_o,
   output logic          fire
);
   localparam int CNT_LSB = FLAG_W;
   localparam int RLD_LSB = FLAG_W + CW;
   localparam int SA_LSB  = FLAG_W + 2 * CW;
   localparam int DA_LSB  = SA_LSB + AW;

   logic [CW-1:0] cnt, rld, cnt_n;
   logic [AW-1:0] sa, da, sa_n, da_n;
   logic          rpt, expire, wrap;

   assign cnt    = rec_i[CNT_LSB +: CW];
   assign rld    = rec_i[RLD_LSB +: CW];
   assign sa     = rec_i[SA_LSB +: AW];
   assign da     = rec_i[DA_LSB +: AW];
   assign rpt    = rec_i[F_RPT];
   assign expire = (cnt == CW'(1));
   assign wrap   = rpt && expire;
   assign fire   = expire && (!rpt || rec_i[F_RPTINT]);

   assign cnt_n = wrap ? rld : cnt - CW'(1);

   always_comb begin
      sa_n = sa + AW'(rec_i[F_SINC]);
      da_n = da + AW'(rec_i[F_DINC]);
      if (wrap && !rec_i[F_RSIDE] && rec_i[F_SINC]) sa_n = sa + AW'(1) - AW'(rld);
      if (wrap &&  rec_i[F_RSIDE] && rec_i[F_DINC]) da_n = da + AW'(1) - AW'(rld);
   end

   assign rec_o = {da_n, sa_n, rld, cnt_n, rec_i[FLAG_W-1:0]};
endmodule

// File: rtl/xfer_chain_seq.sv
module xfer_chain_seq
   import xcs_pkg::*;
#(
   parameter int          NUM_SRC  = 8,
   parameter int          NUM_REC  = 24,
   parameter int          CTL_AW   = 6,
   parameter int          REC_BASE = 8,
   parameter int          ADDR_W   = 16,
   parameter int          CNT_W    = 8,
   parameter int          DATA_W   = 8,
   parameter logic [7:0]  RX_MASK  = 8'h0F,
   localparam int         SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int         REC_W    = FLAG_W + 2 * CNT_W + 2 * ADDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_in,
   input  logic               nmi_flag,
   input  logic               en_wr,
   input  logic [NUM_SRC-1:0] en_wdata,
   output logic [NUM_SRC-1:0] en_q,
   output logic               busy,
   output logic               ctl_req,
   output logic               ctl_we,
   output logic [CTL_AW-1:0]  ctl_addr,
   output logic [REC_W-1:0]   ctl_wdata,
   input  logic [REC_W-1:0]   ctl_rdata,
   input  logic               ctl_ack,
   output logic               dat_req,
   output logic               dat_we,
   output logic [ADDR_W-1:0]  dat_addr,
   output logic [DATA_W-1:0]  dat_wdata,
   input  logic [DATA_W-1:0]  dat_rdata,
   input  logic               dat_ack,
   output logic               dat_clr_ok,
   output logic               irq_pulse,
   output logic [SRC_W-1:0]   irq_src
);
   localparam int IDX_W  = $clog2(NUM_REC);
   localparam int SA_LSB = FLAG_W + 2 * CNT_W;
   localparam int DA_LSB = SA_LSB + ADDR_W;

   if (NUM_SRC < 2 || NUM_SRC > 8) begin : g_bad_src
      $error("NUM_SRC must lie in 2..8");
   end
   if (NUM_REC < 2) begin : g_bad_rec
      $error("NUM_REC must be at least 2");
   end
   if (REC_BASE < NUM_SRC || REC_BASE + NUM_REC > (1 << CTL_AW)) begin : g_bad_map
      $error("record area must sit above the vectors and fit the control space");
   end
   if (CNT_W < 2 || IDX_W > REC_W) begin : g_bad_w
      $error("counter or index width out of range");
   end

   seq_st_e             st_q;
   logic [SRC_W-1:0]    src_q;
   logic [IDX_W-1:0]    idx_q;
   logic [REC_W-1:0]    rec_q, rec_nxt;
   logic [DATA_W-1:0]   dat_q;
   logic                nof_q, irq_q;
   logic [SRC_W-1:0]    irq_src_q;
   logic                pend_any, take, fire, en_clr;
   logic [SRC_W-1:0]    pick_idx;
   logic [CTL_AW-1:0]   rec_addr;

   assign take   = (st_q == S_IDLE) && pend_any;
   assign en_clr = (st_q == S_WB) && ctl_ack && fire;

   xcs_pend #(.NS(NUM_SRC), .SW(SRC_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .en_q(en_q),
      .take(take), .pend_any(pend_any), .pick_idx(pick_idx)
   );

   xcs_enreg #(.NS(NUM_SRC), .SW(SRC_W)) u_enreg (
      .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
      .clr(en_clr), .clr_idx(src_q), .en_q(en_q)
   );

   xcs_update #(.AW(ADDR_W), .CW(CNT_W), .RW(REC_W)) u_upd (
      .rec_i(rec_q), .rec_o(rec_nxt), .fire(fire)
   );

   assign rec_addr = CTL_AW'(REC_BASE) + CTL_AW'(idx_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         src_q     <= '0;
         idx_q     <= '0;
         rec_q     <= '0;
         dat_q     <= '0;
         nof_q     <= 1'b0;
         irq_q     <= 1'b0;
         irq_src_q <= '0;
      end else begin
         irq_q <= 1'b0;
         unique case (st_q)
            S_IDLE: if (pend_any && !nmi_flag) begin
               src_q <= pick_idx;
               nof_q <= 1'b0;
               st_q  <= S_VEC;
            end
            S_VEC: if (ctl_ack) begin
               idx_q <= ctl_rdata[IDX_W-1:0];
               st_q  <= S_REC;
            end
            S_REC: if (ctl_ack) begin
               rec_q <= ctl_rdata;
               st_q  <= S_DRD;
            end
            S_DRD: if (dat_ack) begin
               dat_q <= dat_rdata;
               st_q  <= S_DWR;
            end
            S_DWR: if (dat_ack) st_q <= S_WB;
            S_WB: if (ctl_ack) begin
               if (fire) begin
                  nof_q <= 1'b1;
                  if (RX_MASK[src_q]) begin
                     irq_q     <= 1'b1;
                     irq_src_q <= src_q;
                  end
               end
               if (rec_q[F_CHAIN]) begin
                  idx_q <= idx_q + IDX_W'(1);
                  st_q  <= S_REC;
               end else begin
                  st_q  <= S_IDLE;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      ctl_req   = 1'b0;
      ctl_we    = 1'b0;
      ctl_addr  = CTL_AW'(src_q);
      ctl_wdata = rec_nxt;
      dat_req   = 1'b0;
      dat_we    = 1'b0;
      dat_addr  = rec_q[SA_LSB +: ADDR_W];
      dat_wdata = dat_q;
      case (st_q)
         S_VEC: ctl_req = 1'b1;
         S_REC: begin
            ctl_req  = 1'b1;
            ctl_addr = rec_addr;
         end
         S_DRD: dat_req = 1'b1;
         S_DWR: begin
            dat_req  = 1'b1;
            dat_we   = 1'b1;
            dat_addr = rec_q[DA_LSB +: ADDR_W];
         end
         S_WB: begin
            ctl_req  = 1'b1;
            ctl_we   = 1'b1;
            ctl_addr = rec_addr;
         end
         default: ;
      endcase
   end

   assign busy       = (st_q != S_IDLE);
   assign dat_clr_ok = dat_req && !nof_q;
   assign irq_pulse  = irq_q;
   assign irq_src    = irq_src_q;
endmodule

// File: rtl/xcs_chk.sv
module xcs_chk #(
   parameter int NS = 8,
   parameter int SW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          ctl_req,
   input logic          ctl_we,
   input logic          dat_req,
   input logic          dat_we,
   input logic          irq_pulse,
   input logic          en_wr,
   input logic [SW-1:0] irq_src,
   input logic [NS-1:0] en_q
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ctl_req && !dat_req));

   // R4
   one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_req && dat_req));

   // R4
   vector_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (ctl_req && !ctl_we));

   // R4
   write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dat_req && dat_we) |-> $past(dat_req && !dat_we));

   // R9
   irq_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pulse && !$past(en_wr)) |-> !en_q[irq_src]);

   // R9
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);
endmodule

bind xfer_chain_seq xcs_chk #(.NS(NUM_SRC), .SW(SRC_W)) u_chk (.*);

// File: tb/xfer_chain_seq_tb.sv
module xfer_chain_seq_tb;
   localparam int NS = 8, NR = 24, CAW = 6, RB = 8, AW = 16, CW = 8, DW = 8;
   localparam int RW = 6 + 2 * CW + 2 * AW;
   localparam logic [7:0] RXM = 8'h0F;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NS-1:0] req_in = '0, en_wdata = '0, en_q;
   logic nmi_flag = 1'b0, en_wr = 1'b0;
   logic busy, ctl_req, ctl_we, ctl_ack, dat_req, dat_we, dat_ack, dat_clr_ok, irq_pulse;
   logic [CAW-1:0] ctl_addr;
   logic [RW-1:0]  ctl_wdata, ctl_rdata;
   logic [AW-1:0]  dat_addr;
   logic [DW-1:0]  dat_wdata, dat_rdata;
   logic [2:0]     irq_src;

   always #10 clk = ~clk;

   xfer_chain_seq u_dut (.*);

   // single-cycle memory stub
   logic [RW-1:0] ctl_mem [64];
   logic [7:0]    dat_mem [256];
   assign ctl_ack   = ctl_req;
   assign dat_ack   = dat_req;
   assign ctl_rdata = ctl_mem[ctl_addr];
   assign dat_rdata = dat_mem[dat_addr[7:0]];
   always @(posedge clk) begin
      if (ctl_req && ctl_we) ctl_mem[ctl_addr] <= ctl_wdata;
      if (dat_req && dat_we) dat_mem[dat_addr[7:0]] <= dat_wdata;
   end

   // monitor
   int irq_cnt = 0, clr_cnt = 0, vec_n = 0, stray = 0, busy_seen = 0;
   logic [2:0] last_irq = '0;
   logic [2:0] vec_log [16];
   always @(posedge clk) begin
      if (irq_pulse) begin irq_cnt <= irq_cnt + 1; last_irq <= irq_src; end
      if (dat_req && dat_clr_ok) clr_cnt <= clr_cnt + 1;
      if (ctl_req && !ctl_we && ctl_addr < CAW'(RB)) begin
         vec_log[vec_n[3:0]] <= ctl_addr[2:0];
         vec_n <= vec_n + 1;
      end
      if (busy) busy_seen <= busy_seen + 1;
      if ((ctl_req || dat_req) && !busy) stray <= stray + 1;
   end

   // expected state
   logic [RW-1:0] exp_ctl [64];
   logic [7:0]    exp_dat [256];
   logic [NS-1:0] exp_en = '0;
   int exp_irq, exp_clr, n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, got, exp);
      end
   endtask

   function automatic logic [RW-1:0] mkrec(input logic [5:0] fl, input logic [7:0] c,
                                           input logic [7:0] r, input logic [15:0] s,
                                           input logic [15:0] d);
      return {d, s, r, c, fl};
   endfunction

   // reference model of one activation (R4-R11)
   task automatic model_act(input int s);
      logic [4:0] idx;
      bit fired = 0;
      idx = exp_ctl[s][4:0];
      forever begin
         logic [RW-1:0] r;
         logic [7:0] c, rl;
         logic [15:0] sa, da, san, dan;
         bit rpt, wrap, fire;
         r  = exp_ctl[RB + int'(idx)];
         c  = r[13:6];  rl = r[21:14];  sa = r[37:22];  da = r[53:38];
         rpt = r[0];
         exp_dat[da[7:0]] = exp_dat[sa[7:0]];
         if (!fired) exp_clr += 2;
         wrap = rpt && (c == 8'd1);
         fire = (c == 8'd1) && (!rpt || r[3]);
         san = sa + {15'd0, r[4]};
         dan = da + {15'd0, r[5]};
         if (wrap && !r[1] && r[4]) san = sa + 16'd1 - {8'd0, rl};
         if (wrap &&  r[1] && r[5]) dan = da + 16'd1 - {8'd0, rl};
         exp_ctl[RB + int'(idx)] = mkrec(r[5:0], wrap ? rl : c - 8'd1, rl, san, dan);
         if (fire) begin
            exp_en[s] = 1'b0;
            if (RXM[s]) exp_irq++;
            fired = 1;
         end
         if (!r[2]) break;
         idx = idx + 5'd1;
      end
   endtask

   task automatic settle();
      int q = 0;
      while (q < 3) begin
         @(negedge clk);
         q = busy ? 0 : q + 1;
      end
   endtask

   task automatic set_en(input logic [NS-1:0] m);
      @(negedge clk); en_wr = 1'b1; en_wdata = m;
      @(negedge clk); en_wr = 1'b0;
      exp_en = m;
   endtask

   task automatic pulse(input logic [NS-1:0] m);
      @(negedge clk); req_in = m;
      @(negedge clk); req_in = '0;
   endtask

   task automatic put_rec(input int a, input logic [RW-1:0] v);
      ctl_mem[a] <= v;
      exp_ctl[a] = v;
   endtask

   task automatic compare_all(input string tag);
      int mc = 0, md = 0;
      for (int i = 0; i < 64; i++) if (ctl_mem[i] !== exp_ctl[i]) mc++;
      for (int i = 0; i < 256; i++) if (dat_mem[i] !== exp_dat[i]) md++;
      chk({tag, " R5 R6 R7 R8 record memory mismatches"}, 64'(mc), 64'd0);
      chk({tag, " R4 data memory mismatches"}, 64'(md), 64'd0);
      chk({tag, " R9 R10 enable bits"}, 64'(en_q), 64'(exp_en));
   endtask

   task automatic rand_all();
      @(negedge clk);
      for (int i = 0; i < NS; i++) put_rec(i, {RW'($urandom), 5'($urandom % NR)});
      for (int i = 0; i < NR; i++) begin
         logic [5:0] fl;
         fl = 6'($urandom);
         fl[2] = ($urandom % 3 == 0) && (i != NR - 1);
         put_rec(RB + i, mkrec(fl, 8'(1 + $urandom % 3), 8'(1 + $urandom % 4),
                               16'($urandom), 16'($urandom)));
      end
      for (int i = 0; i < 256; i++) begin
         logic [7:0] b;
         b = 8'($urandom);
         dat_mem[i] <= b;
         exp_dat[i] = b;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int i0, c0, v0, b0;
      void'($urandom(32'd20110805));
      for (int i = 0; i < 64; i++) begin ctl_mem[i] = '0; exp_ctl[i] = '0; end
      for (int i = 0; i < 256; i++) begin dat_mem[i] = '0; exp_dat[i] = '0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", 64'(busy), 0);
      chk("R1 enables", 64'(en_q), 0);
      chk("R1 irq", 64'(irq_pulse), 0);
      chk("R1 requests", 64'(ctl_req | dat_req), 0);
      rst_n = 1'b1;
      rand_all();

      // R2 disabled source ignored
      set_en(8'hFE);
      b0 = busy_seen;
      pulse(8'h01);
      settle();
      chk("R2 busy for disabled source", 64'(busy_seen - b0), 0);
      compare_all("R2");

      // R3 non-maskable flag discards request
      set_en(8'hFF);
      nmi_flag = 1'b1;
      b0 = busy_seen;
      pulse(8'h08);
      settle();
      nmi_flag = 1'b0;
      chk("R3 busy under nmi", 64'(busy_seen - b0), 0);
      compare_all("R3");

      // R7 R10 repeat expiry without interrupt flag; src 1 -> record 5
      @(negedge clk);
      put_rec(1, RW'(5));
      put_rec(RB + 5, mkrec(6'b110001, 8'd1, 8'd4, 16'h0010, 16'h0040));
      set_en(8'hFF);
      i0 = irq_cnt; exp_irq = 0; exp_clr = 0;
      pulse(8'h02);
      model_act(1);
      settle();
      chk("R7 reload count", 64'(ctl_mem[RB + 5][13:6]), 64'd4);
      chk("R7 restart address", 64'(ctl_mem[RB + 5][37:22]), 64'h000D);
      chk("R10 no irq", 64'(irq_cnt - i0), 0);
      compare_all("R10");

      // R10 R9 repeat expiry with interrupt flag
      @(negedge clk);
      put_rec(RB + 5, mkrec(6'b111001, 8'd1, 8'd3, 16'h0020, 16'h0050));
      i0 = irq_cnt; exp_irq = 0;
      pulse(8'h02);
      model_act(1);
      settle();
      chk("R10 irq count", 64'(irq_cnt - i0), 64'(exp_irq));
      chk("R9 irq source", 64'(last_irq), 64'd1);
      compare_all("R10b");

      // R12 simultaneous requests, then requests held during busy
      rand_all();
      set_en(8'hFF);
      v0 = vec_n;
      pulse(8'h64);
      model_act(2); model_act(5); model_act(6);
      settle();
      chk("R12 first", 64'(vec_log[v0[3:0]]), 64'd2);
      chk("R12 second", 64'(vec_log[4'(v0 + 1)]), 64'd5);
      chk("R12 third", 64'(vec_log[4'(v0 + 2)]), 64'd6);
      set_en(8'hFF);
      v0 = vec_n;
      pulse(8'h10);
      @(negedge clk);
      pulse(8'h03);
      model_act(4); model_act(0); model_act(1);
      settle();
      chk("R12 held order a", 64'(vec_log[v0[3:0]]), 64'd4);
      chk("R12 held order b", 64'(vec_log[4'(v0 + 1)]), 64'd0);
      chk("R12 held order c", 64'(vec_log[4'(v0 + 2)]), 64'd1);
      exp_en = en_q;
      compare_all("R12");

      // random activations: R4 R5 R6 R7 R8 R9 R10 R11
      for (int it = 0; it < 80; it++) begin
         int s;
         bit nmi, en_s;
         logic [NS-1:0] m;
         if (it % 10 == 0) rand_all();
         s = $urandom % NS;
         m = NS'($urandom);
         if ($urandom % 8 != 0) m[s] = 1'b1;
         nmi = ($urandom % 8 == 0);
         set_en(m);
         en_s = m[s];
         i0 = irq_cnt; c0 = clr_cnt; exp_irq = 0; exp_clr = 0;
         nmi_flag = nmi;
         pulse(NS'(1) << s);
         if (!nmi && en_s) model_act(s);
         settle();
         nmi_flag = 1'b0;
         chk("R9 irq count", 64'(irq_cnt - i0), 64'(exp_irq));
         chk("R11 clear-qualified accesses", 64'(clr_cnt - c0), 64'(exp_clr));
         compare_all("rand");
      end
      chk("R4 accesses only while busy", 64'(stray), 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule